// File: doc/BRIEF.md
# ADC serial output shifter

This block is the read-side logic of a sampling converter. It keeps the most recent 12-bit conversion result in an output register and sends it to an external host on a serial clock that the host supplies. Each read is a 16-bit frame: four zero bits come first, then the result, most significant bit first, in straight binary. The data pin has its own output-enable, so the pin can be released after the last bit.

The block runs on a fast system clock. The host serial clock and the convert-start line are asynchronous inputs. Each passes through a two-stage synchronizer, and its edges are found in the system clock domain. The first rising serial-clock edge of a frame enables the pin and presents the first zero. Each falling edge after that moves to the next bit. The sixteenth falling edge releases the pin. If the host keeps clocking, the frame starts again from the top. The read position is cleared only by a falling convert-start edge that arrives while the serial clock is low. A falling convert-start edge that arrives while the serial clock is high has no effect.

A result-load strobe writes a new value into the output register at the end of each conversion. The frame being shifted is a copy taken when the frame starts. A new result therefore never corrupts a read that is already in progress.

Top module: `adc_sout`

## Requirements
- R1: A frame is 16 bits, in transmit order: bits 0 to 3 are 0, and bits 4 to 15 are the result from bit 11 down to bit 0 (straight binary). Frame bit k equals bit (15-k) of {4'b0000, result}.
- R2: Only falling serial-clock edges move the line to the next bit. A rising edge that arrives while the pin is enabled leaves the data and enable outputs unchanged.
- R3: A rising serial-clock edge that arrives while the pin is released starts a frame. sdo_oe_o goes to 1 and sdo_o shows frame bit 0 (a zero).
- R4: The LSB (frame bit 15) appears after the 15th falling edge and stays through the next high phase. The 16th falling edge sets sdo_oe_o to 0.
- R5: A rising edge after the 16th falling edge starts a new frame from bit 0. Once the serial clock stops, the pin stays enabled with its current bit for as long as the clock is idle.
- R6: A falling convert-start edge while the synchronized serial clock is low clears the read position and releases the pin. The next rising edge then starts a fresh frame. A falling convert-start edge while the serial clock is high is ignored, and the read continues.
- R7: A load pulse writes result_i into the output register. A frame already in progress keeps its copy. The new value is sent from the next frame start onwards.
- R8: After reset, sdo_oe_o and sdo_o are 0 until the first rising serial-clock edge.
- R9: Whenever sdo_oe_o is 0, sdo_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | End-of-conversion strobe; writes result_i into the output register |
| result_i | input | 12 | Conversion result |
| cnv_i | input | 1 | Convert-start, asynchronous; a falling edge may clear the read position |
| sck_i | input | 1 | Host serial clock, asynchronous |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Output-enable for the data pin (1 = driven) |

## Verification
Two situations are the hardest to reach from the ports. The first is a convert-start falling edge that lands while the serial clock is high. The bench reaches it by holding the clock high for a full phase, lowering convert-start inside that phase, and then checking that the bit sequence continues unbroken. The second is a load that arrives partway through a frame. The bench reaches it by reading six bits, loading a different value, finishing the old frame, and then clocking straight into a wrap-around frame that must carry the new value. A sweep of 48 result values, including all-zeros, all-ones and walking ones, covers the framing of every bit position.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;

    // Edge information for one synchronized input
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_t;

    // What the frame controller does in a given system-clock cycle
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_RESYNC  = 2'd1,
        EV_START   = 2'd2,
        EV_ADVANCE = 2'd3
    } frame_ev_e;

endpackage

// File: rtl/adc_sout_sync.sv
module adc_sout_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            if (s == 0) begin : g_first
                assign stage_d = async_i;
            end else begin : g_next
                assign stage_d = chain_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= stage_d;
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_sout_edge.sv
module adc_sout_edge
    import adc_sout_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl_i,
    output edge_t edge_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d      = lvl_i;
        edge_o.lvl  = lvl_i;
        edge_o.rise = lvl_i & ~prev_q;
        edge_o.fall = ~lvl_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/adc_sout_hold.sv
module adc_sout_hold #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) word_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign data_o = word_q;

endmodule

// File: rtl/adc_sout_frame.sv
module adc_sout_frame
    import adc_sout_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_lvl_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              cnv_fall_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              sdo_o,
    output logic              oe_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);

    localparam int               PAD_W    = FRAME_W - DATA_W;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic               oe;
        logic               sdo;
    } state_t;

    state_t    st_d, st_q;
    frame_ev_e ev;
    logic [FRAME_W-1:0] snap;

    // Frame image: zero padding above the result, chosen by generate
    generate
        if (PAD_W > 0) begin : g_pad
            assign snap = {{PAD_W{1'b0}}, word_i};
        end else begin : g_nopad
            assign snap = word_i[FRAME_W-1:0];
        end
    endgenerate

    // Event priority: resync beats a coincident serial-clock edge
    always_comb begin
        if (cnv_fall_i && !sck_lvl_i)  ev = EV_RESYNC;
        else if (sck_rise_i && !st_q.oe) ev = EV_START;
        else if (sck_fall_i && st_q.oe)  ev = EV_ADVANCE;
        else                             ev = EV_IDLE;
    end

    always_comb begin
        st_d = st_q;
        unique case (ev)
            EV_RESYNC: begin
                st_d.cnt = '0;
                st_d.oe  = 1'b0;
                st_d.sdo = 1'b0;
            end
            EV_START: begin
                st_d.shift = snap;
                st_d.cnt   = '0;
                st_d.oe    = 1'b1;
                st_d.sdo   = snap[FRAME_W-1];
            end
            EV_ADVANCE: begin
                if (st_q.cnt == LAST_BIT) begin
                    st_d.cnt = '0;
                    st_d.oe  = 1'b0;
                    st_d.sdo = 1'b0;
                end else begin
                    st_d.cnt   = st_q.cnt + 1'b1;
                    st_d.shift = {st_q.shift[FRAME_W-2:0], 1'b0};
                    st_d.sdo   = st_q.shift[FRAME_W-2];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o     = st_q.sdo;
    assign oe_o      = st_q.oe;
    assign bit_cnt_o = st_q.cnt;

endmodule

// File: rtl/adc_sout.sv
module adc_sout
    import adc_sout_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              cnv_i,
    input  logic              sck_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int CNT_W = $clog2(FRAME_W);

    logic [1:0]        raw, synced;
    edge_t             sck_ev, cnv_ev;
    logic              sck_lvl, sck_rise, sck_fall, cnv_fall;
    logic [DATA_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;

    assign raw = {cnv_i, sck_i};

    adc_sout_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b00)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw),
        .sync_o (synced)
    );

    adc_sout_edge #(.RST_VAL(1'b0)) u_sck_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (synced[0]),
        .edge_o(sck_ev)
    );

    adc_sout_edge #(.RST_VAL(1'b0)) u_cnv_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (synced[1]),
        .edge_o(cnv_ev)
    );

    assign sck_lvl  = sck_ev.lvl;
    assign sck_rise = sck_ev.rise;
    assign sck_fall = sck_ev.fall;
    assign cnv_fall = cnv_ev.fall;

    adc_sout_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load_i),
        .data_i(result_i),
        .data_o(word)
    );

    adc_sout_frame #(
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_lvl_i (sck_lvl),
        .sck_rise_i(sck_rise),
        .sck_fall_i(sck_fall),
        .cnv_fall_i(cnv_fall),
        .word_i    (word),
        .sdo_o     (sdo_o),
        .oe_o      (sdo_oe_o),
        .bit_cnt_o (bit_cnt)
    );

endmodule

// File: rtl/adc_sout_chk.sv
module adc_sout_chk #(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = $clog2(FRAME_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo_o,
    input logic             sdo_oe_o,
    input logic             sck_lvl,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             cnv_fall,
    input logic [CNT_W-1:0] bit_cnt
);

    localparam int PAD_W = FRAME_W - DATA_W;

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (sdo_oe_o && int'(bit_cnt) < PAD_W) |-> !sdo_o); // R1
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(sck_rise || sck_fall || cnv_fall) |=> ($stable(sdo_o) && $stable(sdo_oe_o))); // R2
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (sck_rise && !sdo_oe_o) |=> (sdo_oe_o && !sdo_o)); // R3
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n) (sck_fall && sdo_oe_o && int'(bit_cnt) == FRAME_W - 1 && !(cnv_fall && !sck_lvl)) |=> !sdo_oe_o); // R4
    AST_RESYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n) (cnv_fall && !sck_lvl) |=> !sdo_oe_o); // R6
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sdo_oe_o |-> !sdo_o); // R9

endmodule

bind adc_sout adc_sout_chk #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o),
    .sck_lvl (sck_lvl),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .cnv_fall(cnv_fall),
    .bit_cnt (bit_cnt)
);

// File: tb/adc_sout_tb_top.sv
`timescale 1ns/1ps
module adc_sout_tb_top;

    localparam int PH = 8; // system clocks per serial-clock phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [11:0] result_i = '0;
    logic        cnv_i = 1'b1;
    logic        sck_i = 1'b0;
    logic        sdo_o, sdo_oe_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    adc_sout dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .result_i(result_i),
        .cnv_i   (cnv_i),
        .sck_i   (sck_i),
        .sdo_o   (sdo_o),
        .sdo_oe_o(sdo_oe_o)
    );

    function automatic logic fbit(input logic [11:0] v, input int k);
        logic [15:0] f;
        f = {4'b0000, v};
        return f[15-k];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual={oe,sdo}=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic resync();
        cnv_i = 1'b1;
        wait_clk(PH);
        cnv_i = 1'b0;
        wait_clk(PH);
        check("R6 resync releases pin", {sdo_oe_o, sdo_o}, 2'b00);
        check("R9 released pin drives zero", {1'b0, sdo_o}, 2'b00);
    endtask

    task automatic load(input logic [11:0] v);
        @(negedge clk);
        result_i = v;
        load_i   = 1'b1;
        @(negedge clk);
        load_i   = 1'b0;
    endtask

    // Pulses k = first .. first+n-1 of a frame carrying v
    task automatic read_bits(input logic [11:0] v, input int first, input int n, input string note);
        for (int p = 0; p < n; p++) begin
            int k;
            k = first + p;
            sck_i = 1'b1;
            wait_clk(PH);
            if (k == 0) check({"R3 frame start ", note}, {sdo_oe_o, sdo_o}, {1'b1, fbit(v, 0)});
            else        check({"R2 rise keeps bit ", note}, {sdo_oe_o, sdo_o}, {1'b1, fbit(v, k)});
            sck_i = 1'b0;
            wait_clk(PH);
            if (k < 14)       check({"R1 bit order ", note}, {sdo_oe_o, sdo_o}, {1'b1, fbit(v, k + 1)});
            else if (k == 14) check({"R4 LSB shown ", note}, {sdo_oe_o, sdo_o}, {1'b1, fbit(v, 15)});
            else              check({"R4 release after 16th ", note}, {sdo_oe_o, sdo_o}, 2'b00);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [11:0] v, w;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(PH);
        check("R8 reset state", {sdo_oe_o, sdo_o}, 2'b00);
        wait_clk(20);
        check("R8 idle until first rise", {sdo_oe_o, sdo_o}, 2'b00);

        // Sweep of result values
        for (int i = 0; i < 48; i++) begin
            if (i == 0)       v = 12'h000;
            else if (i == 1)  v = 12'hFFF;
            else if (i < 14)  v = 12'(1 << (i - 2));
            else              v = 12'((i * 1337 + i * i) % 4096);
            resync();
            load(v);
            read_bits(v, 0, 16, "sweep");
        end

        // R5: wrap-around and idle while driven
        v = 12'hA5C;
        resync();
        load(v);
        read_bits(v, 0, 16, "R5 first");
        read_bits(v, 0, 3, "R5 wrap");
        wait_clk(60);
        check("R5 stays driven after clock stops", {sdo_oe_o, sdo_o}, {1'b1, fbit(v, 3)});

        // R6: resync mid-frame with clock low, then a clean frame
        resync();
        read_bits(v, 0, 7, "R6 partial");
        resync();
        read_bits(v, 0, 16, "R6 fresh");

        // R6: convert-start falling while clock high is ignored
        w = 12'h3C9;
        resync();
        load(w);
        cnv_i = 1'b1;
        wait_clk(PH);
        read_bits(w, 0, 5, "R6 pre");
        sck_i = 1'b1;
        wait_clk(PH);
        cnv_i = 1'b0;
        wait_clk(PH);
        check("R6 high-clock convert ignored", {sdo_oe_o, sdo_o}, {1'b1, fbit(w, 5)});
        sck_i = 1'b0;
        wait_clk(PH);
        check("R6 read continues", {sdo_oe_o, sdo_o}, {1'b1, fbit(w, 6)});
        read_bits(w, 6, 10, "R6 post");

        // R7: load during a read
        v = 12'h7E1;
        w = 12'h81E;
        resync();
        load(v);
        read_bits(v, 0, 6, "R7 old");
        load(w);
        wait_clk(PH);
        check("R7 load mid-frame no effect", {sdo_oe_o, sdo_o}, {1'b1, fbit(v, 6)});
        read_bits(v, 6, 10, "R7 old tail");
        read_bits(w, 0, 16, "R7 new frame");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule